// File: doc/BRIEF.md
# Shift-Down Sample FIFO with Status and Control Register

This block buffers conversion results between a sampling converter and a host processor. Each result is a 12-bit two's complement sample plus one flag that marks the sample as out of range. A result presented on the converter port is stored at the first free location above the words already held. The host always reads location 0. After each read, the words still held move down by one place, so the oldest sample always sits at the read port.

The host uses one 12-bit data bus and one select input. With select low, the host reads samples. With select high, the host reads or writes a status and control word. Through that word the host sets an almost-full threshold, masks the interrupt, and requests a full clear. When read, the same word reports the following:

- the active-low almost-full flag
- a sticky overrun flag
- an empty flag
- the out-of-range state of the whole buffer
- the out-of-range state of the head word
- the index of the highest occupied location

An active-low interrupt output follows the almost-full flag. The host can set the threshold so that it is interrupted only after several samples have collected. Everything runs on one clock.

Top module: `smp_fifo_ctl`

## Requirements
- R1: The asynchronous active-low reset clears the block. A status write with bit 6 set clears it in the same way at the next edge. After either one, every stored word is data 0x800 with its flag clear, the count, overrun, threshold, mask and almost-full state are zero, the status word reads 0x810 and `thr_irq_n` is high.
- R2: With `host_sel` low, `host_rdata` shows bits 11:0 of location 0. A read strobe (`host_rd` with `host_sel` low) moves every remaining word down one location and lowers the count by one, so samples come out in arrival order.
- R3: A read strobe while the buffer is empty changes nothing. When the count is 1, a read lowers the count without shifting, so later reads keep returning the last valid word. Status bit 4 is 1 exactly when the buffer is empty.
- R4: A result that arrives while the buffer holds 8 words is discarded and the stored words are unchanged. It sets status bit 6 (overrun), which stays 1 until the next reset or clear.
- R5: When a read strobe and a result arrive in the same cycle, the read takes effect first. The new word is then stored at the new top, so a full buffer accepts it without overrun.
- R6: Status bits 10:8 hold a threshold T that the host can write and read back. Whenever a result arrives, the almost-full state is set if the resulting count is greater than T. While that state is set and unmasked, `thr_irq_n` and status bit 11 are low. With T = 3, the flag rises on the fourth word.
- R7: After a read strobe, the almost-full state is cleared if the remaining count is not greater than T.
- R8: Status bit 7 is a mask that the host can write and read back. While it is 1, `thr_irq_n` and status bit 11 stay high. The almost-full state is still tracked, and clearing the mask exposes it at once.
- R9: Status bit 5 is 1 if any occupied location holds a flagged word. Status bit 3 is 1 if location 0 is occupied and its word is flagged.
- R10: Status bits 2:0 give the count minus one, or 0 when the buffer is empty.
- R11: Reads with `host_sel` high move no data and change no state. Writes with `host_sel` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset, held low for at least 2 cycles |
| cnv_valid | input | 1 | Converter result present this cycle |
| cnv_data | input | 12 | Two's complement sample |
| cnv_oor | input | 1 | Sample out-of-range flag |
| host_sel | input | 1 | 0 selects sample data, 1 selects the status and control word |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 12 | Host write data |
| host_rdata | output | 12 | Head sample or status word, chosen by `host_sel` |
| thr_irq_n | output | 1 | Active-low almost-full interrupt |

## Verification
The bench targets these corner cases:

- **Read of a one-word buffer.** A design that shifts here would show the stale top location instead of the last valid sample on later reads.
- **Result arriving at a full buffer.** A design that overwrites would corrupt the top sample and miss the overrun flag.
- **Read and result in the same cycle at full.** A design that checks fullness before the read would drop a word that fits.
- **Threshold edge.** The bench checks that the interrupt stays high one word short of the threshold and releases on the read that drops the count back. An off-by-one compare would fire a word early or late.
- **Mask and ignored accesses.** The bench checks that the mask hides the flag without losing it. It also checks that status reads and wrongly selected writes leave the head, count and flags untouched.

// File: rtl/smpf_pkg.sv
package smpf_pkg;

   // Default geometry of the buffer
   localparam int SMPF_DATA_W = 12;
   localparam int SMPF_DEPTH  = 8;

   // Status/control word bit positions (host software decodes these)
   localparam int ST_FLAG_N   = 11;
   localparam int ST_THR_HI   = 10;
   localparam int ST_THR_LO   = 8;
   localparam int ST_MASK     = 7;
   localparam int ST_OVR      = 6;
   localparam int ST_ANY_OOR  = 5;
   localparam int ST_EMPTY    = 4;
   localparam int ST_HEAD_OOR = 3;
   localparam int ST_IDX_HI   = 2;

endpackage

// File: rtl/smpf_store.sv
module smpf_store
   import smpf_pkg::*;
#(
   parameter int DATA_W = SMPF_DATA_W,
   parameter int DEPTH  = SMPF_DEPTH,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rd_req,
   input  logic              cnv_valid,
   input  logic [DATA_W:0]   cnv_word,
   output logic [DATA_W:0]   head,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  cnt_next,
   output logic              any_oor,
   output logic              accept,
   output logic              drop,
   output logic              rd_fire
);

   localparam logic [DATA_W:0]  RST_WORD = {1'b0, 1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [DATA_W:0]  mem_w [DEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_rd;
   logic             full_after_rd;
   logic             shift;

   // Read first, then place any new result at the new top
   assign rd_fire       = rd_req & ~clr;
   assign cnt_rd        = (rd_fire && cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
   assign full_after_rd = (cnt_rd == FULL_CNT);
   assign accept        = cnv_valid & ~clr & ~full_after_rd;
   assign drop          = cnv_valid & ~clr &  full_after_rd;
   assign cnt_next      = cnt_rd + CNT_W'(accept);
   // With a single word held, the count drops but location 0 keeps its word
   assign shift         = rd_fire && (cnt_q > CNT_W'(1));

   for (genvar i = 0; i < DEPTH; i++) begin : g_loc
      logic [DATA_W:0] word_q;
      logic [DATA_W:0] above;
      logic [DATA_W:0] word_d;

      if (i < DEPTH - 1) begin : g_mid
         assign above = mem_w[i+1];
      end else begin : g_top
         assign above = word_q;
      end

      always_comb begin
         word_d = shift ? above : word_q;
         if (accept && cnt_rd == CNT_W'(i)) word_d = cnv_word;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   word_q <= RST_WORD;
         else if (clr) word_q <= RST_WORD;
         else          word_q <= word_d;
      end

      assign mem_w[i] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_next;
   end

   always_comb begin
      any_oor = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CNT_W'(i) < cnt_q) any_oor = any_oor | mem_w[i][DATA_W];
      end
   end

   assign head = mem_w[0];
   assign cnt  = cnt_q;

   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cnt_q == '0 && !cnv_valid && !clr) |=> (cnt_q == '0 && $stable(mem_w[0]))); // R3
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == FULL_CNT && cnv_valid && !rd_req && !clr) |=> (cnt_q == FULL_CNT && $stable(mem_w[DEPTH-1]))); // R4
   AST_SIMUL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == FULL_CNT && cnv_valid && rd_req && !clr) |=> (cnt_q == FULL_CNT && mem_w[DEPTH-1] == $past(cnv_word))); // R5
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT); // R4

endmodule

// File: rtl/smpf_ctl.sv
module smpf_ctl
   import smpf_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             clr,
   input  logic [IDX_W-1:0] thr_in,
   input  logic             mask_in,
   input  logic             cnv_valid,
   input  logic             accept,
   input  logic             drop,
   input  logic             rd_fire,
   input  logic [CNT_W-1:0] cnt_next,
   output logic [IDX_W-1:0] thr_q,
   output logic             mask_q,
   output logic             ovr_q,
   output logic             flag_q
);

   logic flag_event;
   logic over_thr;

   assign flag_event = accept | drop | rd_fire;
   assign over_thr   = cnt_next > CNT_W'(thr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= '0;
         mask_q <= 1'b0;
         ovr_q  <= 1'b0;
         flag_q <= 1'b0;
      end else if (clr) begin
         thr_q  <= '0;
         mask_q <= 1'b0;
         ovr_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (ctl_wr) begin
            thr_q  <= thr_in;
            mask_q <= mask_in;
         end
         if (drop) ovr_q <= 1'b1;
         if (flag_event) flag_q <= over_thr;
      end
   end

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !clr) |=> ovr_q); // R4
   AST_FLAG_RISE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(cnv_valid)); // R6
   AST_FLAG_CLEAR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && rd_fire && !cnv_valid && cnt_next <= CNT_W'(thr_q)) |=> !flag_q); // R7

endmodule

// File: rtl/smpf_stat.sv
module smpf_stat
   import smpf_pkg::*;
#(
   parameter int DATA_W = SMPF_DATA_W,
   parameter int CNT_W  = 4,
   parameter int IDX_W  = 3
) (
   input  logic              flag,
   input  logic              mask,
   input  logic [IDX_W-1:0]  thr,
   input  logic              ovr,
   input  logic              any_oor,
   input  logic              head_flag,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] status,
   output logic              irq_n
);

   logic             empty;
   logic [CNT_W-1:0] cnt_m1;
   logic [IDX_W-1:0] idx;
   logic             unused_cnt_top;

   assign empty          = (cnt == '0);
   assign cnt_m1         = cnt - CNT_W'(1);
   assign idx            = empty ? '0 : cnt_m1[IDX_W-1:0];
   assign unused_cnt_top = cnt_m1[CNT_W-1];
   assign irq_n          = ~(flag & ~mask);

   always_comb begin
      status                        = '0;
      status[ST_FLAG_N]             = irq_n;
      status[ST_THR_HI:ST_THR_LO]   = thr;
      status[ST_MASK]               = mask;
      status[ST_OVR]                = ovr;
      status[ST_ANY_OOR]            = any_oor;
      status[ST_EMPTY]              = empty;
      status[ST_HEAD_OOR]           = head_flag & ~empty;
      status[ST_IDX_HI:0]           = idx;
   end

endmodule

// File: rtl/smp_fifo_ctl.sv
module smp_fifo_ctl
   import smpf_pkg::*;
#(
   parameter int DATA_W = SMPF_DATA_W,
   parameter int DEPTH  = SMPF_DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_valid,
   input  logic [DATA_W-1:0] cnv_data,
   input  logic              cnv_oor,
   input  logic              host_sel,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              thr_irq_n
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);

   // The status layout is fixed by host software
   if (DATA_W != SMPF_DATA_W || DEPTH != SMPF_DEPTH) begin : g_cfg_bad
      $error("smp_fifo_ctl: status layout needs 12-bit data and depth 8");
   end

   logic              ctl_wr;
   logic              clr;
   logic              rd_req;
   logic [DATA_W:0]   head;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_next;
   logic              any_oor;
   logic              accept;
   logic              drop;
   logic              rd_fire;
   logic [IDX_W-1:0]  thr_q;
   logic              mask_q;
   logic              ovr_q;
   logic              flag_q;
   logic [DATA_W-1:0] status;
   logic              unused_wbits;

   assign ctl_wr       = host_wr & host_sel;
   assign clr          = ctl_wr & host_wdata[ST_OVR];
   assign rd_req       = host_rd & ~host_sel;
   assign unused_wbits = ^{host_wdata[DATA_W-1], host_wdata[ST_ANY_OOR:0]};

   smpf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .rd_req    (rd_req),
      .cnv_valid (cnv_valid),
      .cnv_word  ({cnv_oor, cnv_data}),
      .head      (head),
      .cnt       (cnt),
      .cnt_next  (cnt_next),
      .any_oor   (any_oor),
      .accept    (accept),
      .drop      (drop),
      .rd_fire   (rd_fire)
   );

   smpf_ctl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .clr       (clr),
      .thr_in    (host_wdata[ST_THR_HI:ST_THR_LO]),
      .mask_in   (host_wdata[ST_MASK]),
      .cnv_valid (cnv_valid),
      .accept    (accept),
      .drop      (drop),
      .rd_fire   (rd_fire),
      .cnt_next  (cnt_next),
      .thr_q     (thr_q),
      .mask_q    (mask_q),
      .ovr_q     (ovr_q),
      .flag_q    (flag_q)
   );

   smpf_stat #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_stat (
      .flag      (flag_q),
      .mask      (mask_q),
      .thr       (thr_q),
      .ovr       (ovr_q),
      .any_oor   (any_oor),
      .head_flag (head[DATA_W]),
      .cnt       (cnt),
      .status    (status),
      .irq_n     (thr_irq_n)
   );

   assign host_rdata = host_sel ? status : head[DATA_W-1:0];

   AST_STAT_RD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_sel && !host_wr && !cnv_valid) |=> ($stable(cnt) && $stable(head))); // R11
   AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> thr_irq_n); // R8

endmodule

// File: tb/tb_smp_fifo_ctl.sv
module tb_smp_fifo_ctl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cnv_valid;
   logic [11:0] cnv_data;
   logic        cnv_oor;
   logic        host_sel;
   logic        host_rd;
   logic        host_wr;
   logic [11:0] host_wdata;
   logic [11:0] host_rdata;
   logic        thr_irq_n;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   smp_fifo_ctl dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnv_valid  (cnv_valid),
      .cnv_data   (cnv_data),
      .cnv_oor    (cnv_oor),
      .host_sel   (host_sel),
      .host_rd    (host_rd),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .thr_irq_n  (thr_irq_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
      end
   endtask

   task automatic check_stat(input string req, input logic [11:0] exp);
      host_sel = 1'b1;
      #1;
      check(req, host_rdata, exp);
   endtask

   task automatic check_head(input string req, input logic [11:0] exp);
      host_sel = 1'b0;
      #1;
      check(req, host_rdata, exp);
   endtask

   task automatic check_irq(input string req, input logic exp);
      #1;
      check(req, {11'd0, thr_irq_n}, {11'd0, exp});
   endtask

   task automatic push(input logic [11:0] d, input logic oor);
      @(negedge clk);
      cnv_valid = 1'b1; cnv_data = d; cnv_oor = oor;
      @(negedge clk);
      cnv_valid = 1'b0;
   endtask

   task automatic pop(input string req, input logic [11:0] exp);
      @(negedge clk);
      host_sel = 1'b0; host_rd = 1'b1;
      #1;
      check(req, host_rdata, exp);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wr_ctl(input logic [11:0] v);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      check_stat("R1 status after reset", 12'h810);
      check_head("R1 head after reset", 12'h800);
      check_irq("R1 irq after reset", 1'b1);
   endtask

   task automatic t_order_threshold();
      wr_ctl(12'h300);
      check_stat("R6 threshold readback", 12'hB10);
      push(12'h123, 1'b0);
      push(12'h7FF, 1'b1);
      push(12'hF00, 1'b0);
      check_stat("R10 R9 three words", 12'hB22);
      check_irq("R6 irq one short of threshold", 1'b1);
      push(12'h001, 1'b0);
      check_stat("R6 flag at fourth word", 12'h323);
      check_irq("R6 irq at fourth word", 1'b0);
      pop("R2 first out", 12'h123);
      check_stat("R7 R9 flag released, head flagged", 12'hB2A);
      check_irq("R7 irq released", 1'b1);
      pop("R2 second out", 12'h7FF);
      check_stat("R9 no flagged word left", 12'hB01);
      pop("R2 third out", 12'hF00);
      pop("R2 fourth out", 12'h001);
      check_stat("R3 empty after drain", 12'hB10);
      pop("R3 read when empty keeps last word", 12'h001);
      check_stat("R3 empty read changes nothing", 12'hB10);
   endtask

   task automatic t_full_overrun();
      wr_ctl(12'h040);
      check_stat("R1 soft clear status", 12'h810);
      check_head("R1 soft clear head", 12'h800);
      for (int i = 1; i <= 8; i++) push(12'(i * 16), 1'b0);
      check_stat("R4 full without overrun", 12'h007);
      push(12'h0F0, 1'b0);
      check_stat("R4 overrun set", 12'h047);
      check_irq("R6 irq with threshold 0", 1'b0);
      for (int i = 1; i <= 8; i++) pop("R4 dropped word absent", 12'(i * 16));
      check_stat("R4 overrun sticky when empty", 12'h850);
      check_irq("R7 irq released when empty", 1'b1);
   endtask

   task automatic t_simultaneous();
      wr_ctl(12'h040);
      for (int i = 0; i < 8; i++) push(12'h100 + 12'(i), 1'b0);
      @(negedge clk);
      host_sel = 1'b0; host_rd = 1'b1;
      cnv_valid = 1'b1; cnv_data = 12'h3AB; cnv_oor = 1'b1;
      #1;
      check("R5 read side of simultaneous access", host_rdata, 12'h100);
      @(negedge clk);
      host_rd = 1'b0; cnv_valid = 1'b0;
      check_stat("R5 full, no overrun", 12'h027);
      for (int i = 1; i < 8; i++) pop("R5 order kept", 12'h100 + 12'(i));
      pop("R5 new word at top", 12'h3AB);
      check_stat("R5 R7 drained", 12'h810);
   endtask

   task automatic t_mask_and_ignore();
      wr_ctl(12'h040);
      wr_ctl(12'h080);
      check_stat("R8 mask readback", 12'h890);
      push(12'h555, 1'b0);
      check_stat("R8 masked flag hidden", 12'h880);
      check_irq("R8 masked irq high", 1'b1);
      wr_ctl(12'h000);
      check_stat("R8 unmask exposes flag", 12'h000);
      check_irq("R8 unmask drives irq", 1'b0);
      @(negedge clk);
      host_sel = 1'b1; host_rd = 1'b1;
      repeat (3) @(negedge clk);
      host_rd = 1'b0;
      check_stat("R11 status reads move nothing", 12'h000);
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b1; host_wdata = 12'hFFF;
      @(negedge clk);
      host_wr = 1'b0;
      check_stat("R11 write with select low ignored", 12'h000);
      pop("R11 head intact", 12'h555);
   endtask

   task automatic t_hw_reset();
      push(12'h2AA, 1'b1);
      wr_ctl(12'h280);
      hw_reset();
      check_stat("R1 hardware reset status", 12'h810);
      check_head("R1 hardware reset head", 12'h800);
      check_irq("R1 hardware reset irq", 1'b1);
   endtask

   initial begin
      rst_n = 1'b0; cnv_valid = 1'b0; cnv_data = '0; cnv_oor = 1'b0;
      host_sel = 1'b0; host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order_threshold();
      t_full_overrun();
      t_simultaneous();
      t_mask_and_ignore();
      t_hw_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule